// File: doc/BRIEF.md
# Product-Term Cluster Allocator

This block steers the results of sixty-four product terms onto sixteen macrocell sum inputs inside one logic block of a programmable-logic fabric. The terms are taken four at a time as sixteen clusters. A cluster first collapses its four terms into one OR result. That result is then delivered to exactly one macrocell, or to none. Each macrocell output is the OR of every cluster routed to it, so a macrocell can collect up to four clusters (sixteen terms).

Routing is not a free crossbar. A cluster may only reach macrocells near its own position: macrocell n may use clusters n-1 up to n+2, and the window is clipped at both ends of the array. A static configuration register holds one field per cluster, made of a valid bit and a four-bit target index. It is loaded in a single write. When any valid field names a macrocell outside its cluster's window, an error flag is raised and that cluster is dropped. The special-purpose terms (output enables, asynchronous reset and preset) never pass through this block.

Top module: `ptc_alloc`

## Requirements
- R1: While rst_ni is low and after it is released, every configuration field is cleared (invalid), so mc_o is 0 and err_o is 0 for any pt_i until the first write.
- R2: Cluster c covers pt_i bits [4c+3:4c]. Its value is the OR of those four bits. Bits outside the cluster never reach the cluster's macrocell.
- R3: mc_o[n] is the OR of the values of all clusters whose field is valid, targets n and is legal. A cluster drives at most one macrocell.
- R4: Target n is legal for cluster c exactly when c-2 <= n <= c+1 and 0 <= n <= 15. So M0 may use C0..C2, M1 C0..C3, M14 C13..C15 and M15 C14..C15.
- R5: err_o is 1 while any valid field holds an illegal target. Such a cluster contributes nothing to mc_o, and legal clusters keep working.
- R6: A field whose valid bit is 0 contributes nothing and never raises err_o, whatever its target bits hold.
- R7: A macrocell with no legal valid cluster assigned outputs 0.
- R8: cfg_i is captured on a rising clk_i edge when cfg_we_i is 1. While cfg_we_i is 0, cfg_i has no effect on mc_o or err_o. Field c sits at cfg_i[5c+4:5c]: bit 4 is the valid bit and bits 3:0 are the target index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the configuration register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load cfg_i into the configuration register |
| cfg_i | input | 80 | Sixteen 5-bit fields {valid, target[3:0]} |
| pt_i | input | 64 | Product-term results, four per cluster |
| mc_o | output | 16 | Combined sum per macrocell |
| err_o | output | 1 | An illegal assignment is present |

## Verification
A corrupted configuration field shows up at the ports as soon as the term bits of that cluster are driven. The cluster's value lands on the wrong macrocell or on no macrocell, or err_o goes wrong, all in the same cycle, because the path from pt_i to mc_o has no register. The bench therefore excites one cluster at a time and checks the whole mc_o vector, not just the intended bit. It probes window edges from both sides and at both array ends. It also checks that err_o and mc_o stay unchanged while writes are disabled.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int NUM_CLU   = 16;
  localparam int TERMS_CLU = 4;
  localparam int NUM_MC    = 16;
  localparam int WIN_BELOW = 1;   // clusters below macrocell index
  localparam int WIN_ABOVE = 2;   // clusters above macrocell index
  localparam int NUM_PT    = NUM_CLU * TERMS_CLU;
  localparam int MC_IDX_W  = $clog2(NUM_MC);
  localparam int FIELD_W   = MC_IDX_W + 1;
  localparam int CFG_W     = NUM_CLU * FIELD_W;

  typedef struct packed {
    logic                vld;
    logic [MC_IDX_W-1:0] tgt;
  } clu_cfg_t;

  function automatic logic in_window(int clu, int mc);
    return (mc >= 0) && (mc < NUM_MC) &&
           (clu >= mc - WIN_BELOW) && (clu <= mc + WIN_ABOVE);
  endfunction
endpackage

// File: rtl/ptc_cluster_or.sv
module ptc_cluster_or #(
  parameter int W = 4
) (
  input  logic [W-1:0] terms_i,
  output logic         sum_o
);
  assign sum_o = |terms_i;
endmodule

// File: rtl/ptc_cluster_route.sv
module ptc_cluster_route
  import ptc_pkg::*;
#(
  parameter int CLU = 0
) (
  input  clu_cfg_t          cfg_i,
  input  logic              val_i,
  output logic [NUM_MC-1:0] drv_o,
  output logic              bad_o
);
  logic legal;

  assign legal = in_window(CLU, int'(cfg_i.tgt));
  assign bad_o = cfg_i.vld && !legal;

  always_comb begin
    drv_o = '0;
    for (int n = 0; n < NUM_MC; n++) begin
      drv_o[n] = cfg_i.vld && legal && (int'(cfg_i.tgt) == n) && val_i;
    end
  end
endmodule

// File: rtl/ptc_alloc.sv
module ptc_alloc
  import ptc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [NUM_PT-1:0] pt_i,
  output logic [NUM_MC-1:0] mc_o,
  output logic              err_o
);
  clu_cfg_t [NUM_CLU-1:0]             cfg_q;
  logic     [NUM_CLU-1:0]             clu_val;
  logic     [NUM_CLU-1:0]             clu_bad;
  logic     [NUM_CLU-1:0][NUM_MC-1:0] clu_drv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= cfg_i;
  end

  for (genvar c = 0; c < NUM_CLU; c++) begin : g_clu
    ptc_cluster_or #(.W(TERMS_CLU)) u_or (
      .terms_i (pt_i[c*TERMS_CLU +: TERMS_CLU]),
      .sum_o   (clu_val[c])
    );
    ptc_cluster_route #(.CLU(c)) u_route (
      .cfg_i (cfg_q[c]),
      .val_i (clu_val[c]),
      .drv_o (clu_drv[c]),
      .bad_o (clu_bad[c])
    );
  end

  always_comb begin
    mc_o = '0;
    for (int c = 0; c < NUM_CLU; c++) mc_o |= clu_drv[c];
  end

  assign err_o = |clu_bad;
endmodule

// File: rtl/ptc_alloc_chk.sv
module ptc_alloc_chk
  import ptc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [NUM_PT-1:0] pt_i,
  input logic [NUM_MC-1:0] mc_o,
  input logic              err_o
);
  logic [NUM_CLU-1:0] act;

  always_comb begin
    for (int c = 0; c < NUM_CLU; c++) act[c] = |pt_i[c*TERMS_CLU +: TERMS_CLU];
  end

  // R2
  no_spurious_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pt_i == '0) |-> (mc_o == '0));

  // R3
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(act) <= 1) |-> $onehot0(mc_o));

  // R8
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(err_o));

  for (genvar c = 0; c < NUM_CLU; c++) begin : g_win
    logic [NUM_MC-1:0] win;
    always_comb begin
      for (int n = 0; n < NUM_MC; n++) win[n] = in_window(c, n);
    end
    // R4
    window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act == (NUM_CLU'(1) << c)) |-> ((mc_o & ~win) == '0));
  end
endmodule

bind ptc_alloc ptc_alloc_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cfg_we_i (cfg_we_i),
  .pt_i     (pt_i),
  .mc_o     (mc_o),
  .err_o    (err_o)
);

// File: tb/tb_ptc_alloc.sv
module tb_ptc_alloc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [79:0] cfg_i = '0;
  logic [63:0] pt_i = '0;
  logic [15:0] mc_o;
  logic        err_o;
  int          n_total = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  ptc_alloc dut (.*);

  always #4 clk_i = ~clk_i;

  typedef struct packed {
    logic [3:0]  clu;
    logic [3:0]  tgt;
    logic        vld;
    logic [63:0] pt;
    logic [15:0] mc;
    logic        err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'd0,  4'd0,  1'b1, 64'h1,                  16'h0001, 1'b0}, // R4 M0 edge
    '{4'd0,  4'd2,  1'b1, 64'h8,                  16'h0000, 1'b1}, // R5
    '{4'd0,  4'd1,  1'b1, 64'h4,                  16'h0002, 1'b0}, // R4
    '{4'd2,  4'd0,  1'b1, 64'h100,                16'h0001, 1'b0}, // R4 M0 uses C2
    '{4'd3,  4'd0,  1'b1, 64'h1000,               16'h0000, 1'b1}, // R5
    '{4'd15, 4'd15, 1'b1, 64'h1000_0000_0000_0000, 16'h8000, 1'b0}, // R4 M15 edge
    '{4'd15, 4'd13, 1'b1, 64'h8000_0000_0000_0000, 16'h2000, 1'b0}, // R4
    '{4'd15, 4'd12, 1'b1, 64'hF000_0000_0000_0000, 16'h0000, 1'b1}, // R5
    '{4'd5,  4'd3,  1'b1, 64'h20_0000,            16'h0008, 1'b0}, // R3
    '{4'd5,  4'd6,  1'b1, 64'h40_0000,            16'h0040, 1'b0}, // R3
    '{4'd5,  4'd7,  1'b1, 64'hF0_0000,            16'h0000, 1'b1}, // R5
    '{4'd5,  4'd2,  1'b1, 64'hF0_0000,            16'h0000, 1'b1}, // R5
    '{4'd5,  4'd4,  1'b0, 64'hF0_0000,            16'h0000, 1'b0}, // R6
    '{4'd5,  4'd4,  1'b1, 64'hFFFF_FFFF_FF0F_FFFF, 16'h0000, 1'b0}, // R2
    '{4'd1,  4'd15, 1'b1, 64'hF0,                 16'h0000, 1'b1}  // R5
  };

  function automatic logic [79:0] fld(int c, int t, bit v);
    logic [79:0] f = '0;
    f[c*5 +: 5] = {v, 4'(t)};
    return f;
  endfunction

  task automatic check(string req, logic [15:0] mc_exp, logic err_exp);
    n_total++;
    if (mc_o !== mc_exp || err_o !== err_exp) begin
      n_fail++;
      $display("FAIL %s: mc=%h err=%b expected mc=%h err=%b", req, mc_o, err_o, mc_exp, err_exp);
    end
  endtask

  task automatic load(logic [79:0] cfg);
    @(negedge clk_i);
    cfg_i = cfg;
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    pt_i = '1;
    #1 check("R1 in reset", 16'h0, 1'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 check("R1 after reset", 16'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      load(fld(int'(TBL[i].clu), int'(TBL[i].tgt), TBL[i].vld));
      pt_i = TBL[i].pt;
      #1 check($sformatf("table %0d", i), TBL[i].mc, TBL[i].err);
    end

    // R3 / R7 several clusters sharing macrocells
    load(fld(0, 0, 1) | fld(1, 0, 1) | fld(2, 1, 1) | fld(3, 2, 1));
    pt_i = 64'h20;
    #1 check("R3 cluster1 alone", 16'h0001, 1'b0);
    pt_i = 64'h1000;
    #1 check("R3 cluster3 alone", 16'h0004, 1'b0);
    pt_i = '1;
    #1 check("R7 unassigned macrocells zero", 16'h0007, 1'b0);

    // R8 write-enable low ignores cfg_i
    @(negedge clk_i);
    cfg_i = fld(4, 15, 1);
    repeat (2) @(negedge clk_i);
    #1 check("R8 cfg ignored without write", 16'h0007, 1'b0);

    // R5 illegal cluster dropped, legal one kept
    load(fld(0, 0, 1) | fld(4, 0, 1));
    pt_i = '1;
    #1 check("R5 mixed legal and illegal", 16'h0001, 1'b1);

    // R1 reset mid-run clears configuration
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 check("R1 reset clears", 16'h0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1 check("R1 cleared after release", 16'h0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule